// File: doc/BRIEF.md
# Reset control register sequencer

This block holds an 8-bit reset control register that is decoded at a fixed I/O address. It also contains the sequencer that the register starts. When the write sets the reset-CPU bit from 0 to 1, one of two sequences runs. A soft reset drives the processor init output low for a fixed number of bus clocks. A hard reset drives the platform reset and suspend-status outputs low for a few milliseconds. When the full-reset bit is set, the hard reset first drives all three sleep-state outputs low for several seconds, which forces a complete power cycle.

Three events outside the register also start a hard sequence, and each of them honours the full-reset bit: a rising edge on the external system reset request, a falling edge of power-good while the resume well is out of reset, and the second watchdog expiry. A slow tick from an internal prescaler times the millisecond and second windows. The division ratio and the tick counts are parameters, so a simulation can use short windows.

The reset-CPU and system-reset bits are in the main well. A hard sequence clears them, and so does the main reset. The full-reset bit and the watchdog expiry memory are in the resume well, and only the resume reset clears them.

Top module: `rstctl_seq_top`

## Requirements
- R1: After reset, a read of the register returns 00h and all six reset and sleep outputs are high (inactive).
- R2: A write with io_addr equal to IO_ADDR (default 0CF9h) stores bit 3 (full reset), bit 2 (reset CPU) and bit 1 (system reset). Bits 7:4 and bit 0 always read 0. A write to any other address changes nothing. io_rdata is combinational: it shows the register while io_rd is high and the address matches, and 0 at all other times.
- R3: A write that takes bit 2 from 0 to 1 while bit 1 of the written byte is 0 drives cpu_init_n low in the cycle after the write for exactly INIT_CLKS cycles. The other outputs stay high.
- R4: A write with bit 2 set while the stored bit 2 is already 1 starts no sequence.
- R5: A write that takes bit 2 from 0 to 1 while bit 1 of the written byte is 1 and bit 3 is 0 drives plt_rst_n and sus_stat_n low together in the cycle after the write. They stay low for L cycles, where (HARD_TICKS-1)*TICK_DIV < L <= HARD_TICKS*TICK_DIV. The sleep outputs stay high.
- R6: A hard sequence started while the full-reset bit is 1 (for a register write, the bit in the written byte) drives slp_s3_n, slp_s4_n and slp_s5_n low together for S cycles, where (FULL_TICKS-1)*TICK_DIV < S <= FULL_TICKS*TICK_DIV. plt_rst_n goes low in the same cycle and rises exactly HARD_TICKS*TICK_DIV cycles after the sleep outputs rise.
- R7: Bits 2 and 1 return to 0 when a hard sequence starts and when rst_n is asserted. Neither event changes bit 3. Only rsm_rst_n clears bit 3.
- R8: A rising edge on ext_rst_req starts a hard sequence, using the R5 or R6 form according to bit 3.
- R9: A falling edge of pwr_good while rsm_rst_n is high starts a hard sequence.
- R10: A first wdt_expire pulse only arms the block. A second pulse starts a hard sequence and disarms it.
- R11: A trigger of any kind that arrives while a sequence runs is dropped. It neither restarts nor lengthens the sequence, and a register write in that window still updates the register.
- R12: When a soft-reset write and an external hard trigger fall in the same cycle, the hard sequence runs, no init pulse is produced, and bits 2:1 are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Main-well reset, active low |
| rsm_rst_n | input | 1 | Resume-well reset, active low |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (0 when not selected) |
| ext_rst_req | input | 1 | External system reset request, rising-edge sensitive |
| pwr_good | input | 1 | Power-good level |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| cpu_init_n | output | 1 | Processor init, active low |
| plt_rst_n | output | 1 | Platform reset, active low |
| sus_stat_n | output | 1 | Suspend status, active low |
| slp_s3_n | output | 1 | Sleep-state 3 control, active low |
| slp_s4_n | output | 1 | Sleep-state 4 control, active low |
| slp_s5_n | output | 1 | Sleep-state 5 control, active low |

## Verification
The register decoder can start a soft reset, and the external-trigger logic can start a hard reset, on the same clock edge. To provoke this, the bench drives a soft-reset byte to the register and raises ext_rst_req on the same falling edge. It then checks that the init output stays high, that exactly one platform-reset pulse follows, and that the read-back shows bits 2:1 cleared. Trigger arbitration is also exercised while a sequence is running: a register write and an external request are issued mid-sequence, and the bench checks that the pulse count and pulse lengths are the same as for an undisturbed sequence.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
    localparam int unsigned BIT_SYS  = 1;
    localparam int unsigned BIT_CPU  = 2;
    localparam int unsigned BIT_FULL = 3;
    localparam logic [7:0]  MAIN_MASK = 8'h06;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SOFT   = 2'd1,
        SEQ_PWRCYC = 2'd2,
        SEQ_HARD   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/rstctl_tick_gen.sv
module rstctl_tick_gen #(
    parameter int unsigned TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          tick;
    } tick_t;

    tick_t tk_d, tk_q;

    always_comb begin
        tk_d = tk_q;
        if (tk_q.cnt == TW'(TICK_DIV - 1)) begin
            tk_d.cnt  = '0;
            tk_d.tick = 1'b1;
        end else begin
            tk_d.cnt  = tk_q.cnt + TW'(1);
            tk_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign tick_o = tk_q.tick;
endmodule

// File: rtl/rstctl_regfile.sv
module rstctl_regfile
    import rstctl_pkg::*;
#(
    parameter int unsigned        ADDR_W  = 16,
    parameter logic [ADDR_W-1:0]  IO_ADDR = 16'h0CF9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsm_rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    input  logic              hard_clr_i,
    output logic [7:0]        io_rdata,
    output logic              cf9_trig_o,
    output logic              cf9_hard_o,
    output logic              full_eff_o
);
    typedef struct packed {
        logic [7:0] ctl;
    } main_t;

    typedef struct packed {
        logic full;
    } rsm_t;

    main_t main_d, main_q;
    rsm_t  rsm_d,  rsm_q;
    logic  hit, wr_hit, rd_hit;

    assign hit    = (io_addr == IO_ADDR);
    assign wr_hit = io_wr && hit;
    assign rd_hit = io_rd && hit;

    always_comb begin
        main_d = main_q;
        rsm_d  = rsm_q;
        if (wr_hit) begin
            main_d.ctl = io_wdata & MAIN_MASK;
            rsm_d.full = io_wdata[BIT_FULL];
        end
        if (hard_clr_i) begin
            main_d.ctl = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) main_q <= '0;
        else        main_q <= main_d;
    end

    always_ff @(posedge clk or negedge rsm_rst_n) begin
        if (!rsm_rst_n) rsm_q <= '0;
        else            rsm_q <= rsm_d;
    end

    assign cf9_trig_o = wr_hit && io_wdata[BIT_CPU] && !main_q.ctl[BIT_CPU];
    assign cf9_hard_o = io_wdata[BIT_SYS];
    assign full_eff_o = wr_hit ? io_wdata[BIT_FULL] : rsm_q.full;
    assign io_rdata   = rd_hit ? (main_q.ctl | (8'(rsm_q.full) << BIT_FULL)) : 8'h00;
endmodule

// File: rtl/rstctl_trig.sv
module rstctl_trig (
    input  logic clk,
    input  logic rsm_rst_n,
    input  logic idle_i,
    input  logic ext_rst_req,
    input  logic pwr_good,
    input  logic wdt_expire,
    output logic ext_hard_o
);
    typedef struct packed {
        logic req_prev;
        logic pg_prev;
        logic wdt_armed;
    } trig_t;

    trig_t tr_d, tr_q;
    logic  req_rise, pg_fall, wdt_fire;

    assign req_rise = ext_rst_req && !tr_q.req_prev;
    assign pg_fall  = tr_q.pg_prev && !pwr_good;
    assign wdt_fire = wdt_expire && tr_q.wdt_armed;

    always_comb begin
        tr_d          = tr_q;
        tr_d.req_prev = ext_rst_req;
        tr_d.pg_prev  = pwr_good;
        if (idle_i && wdt_expire) begin
            tr_d.wdt_armed = !tr_q.wdt_armed;
        end
    end

    always_ff @(posedge clk or negedge rsm_rst_n) begin
        if (!rsm_rst_n) tr_q <= '0;
        else            tr_q <= tr_d;
    end

    assign ext_hard_o = idle_i && (req_rise || pg_fall || wdt_fire);
endmodule

// File: rtl/rstctl_seq_fsm.sv
module rstctl_seq_fsm
    import rstctl_pkg::*;
#(
    parameter int unsigned INIT_CLKS  = 16,
    parameter int unsigned HARD_TICKS = 6,
    parameter int unsigned FULL_TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic cf9_trig_i,
    input  logic cf9_hard_i,
    input  logic ext_hard_i,
    input  logic full_i,
    output logic idle_o,
    output logic hard_start_o,
    output logic cpu_init_n,
    output logic plt_rst_n,
    output logic sus_stat_n,
    output logic slp_s3_n,
    output logic slp_s4_n,
    output logic slp_s5_n
);
    localparam int unsigned MAX_A = (INIT_CLKS > HARD_TICKS) ? INIT_CLKS : HARD_TICKS;
    localparam int unsigned MAX_C = (MAX_A > FULL_TICKS) ? MAX_A : FULL_TICKS;
    localparam int unsigned CW    = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t fs_d, fs_q;
    logic idle, hard_go, soft_go;

    assign idle    = (fs_q.st == SEQ_IDLE);
    assign hard_go = idle && (ext_hard_i || (cf9_trig_i && cf9_hard_i));
    assign soft_go = idle && cf9_trig_i && !cf9_hard_i && !ext_hard_i;

    always_comb begin
        fs_d = fs_q;
        unique case (fs_q.st)
            SEQ_IDLE: begin
                if (hard_go) begin
                    if (full_i) begin
                        fs_d.st  = SEQ_PWRCYC;
                        fs_d.cnt = CW'(FULL_TICKS);
                    end else begin
                        fs_d.st  = SEQ_HARD;
                        fs_d.cnt = CW'(HARD_TICKS);
                    end
                end else if (soft_go) begin
                    fs_d.st  = SEQ_SOFT;
                    fs_d.cnt = CW'(INIT_CLKS - 1);
                end
            end
            SEQ_SOFT: begin
                if (fs_q.cnt == '0) fs_d.st  = SEQ_IDLE;
                else                fs_d.cnt = fs_q.cnt - CW'(1);
            end
            SEQ_PWRCYC: begin
                if (tick_i) begin
                    if (fs_q.cnt == CW'(1)) begin
                        fs_d.st  = SEQ_HARD;
                        fs_d.cnt = CW'(HARD_TICKS);
                    end else begin
                        fs_d.cnt = fs_q.cnt - CW'(1);
                    end
                end
            end
            SEQ_HARD: begin
                if (tick_i) begin
                    if (fs_q.cnt == CW'(1)) fs_d.st  = SEQ_IDLE;
                    else                    fs_d.cnt = fs_q.cnt - CW'(1);
                end
            end
            default: fs_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '{st: SEQ_IDLE, cnt: '0};
        else        fs_q <= fs_d;
    end

    assign idle_o       = idle;
    assign hard_start_o = hard_go;
    assign cpu_init_n   = (fs_q.st != SEQ_SOFT);
    assign plt_rst_n    = !((fs_q.st == SEQ_HARD) || (fs_q.st == SEQ_PWRCYC));
    assign sus_stat_n   = plt_rst_n;
    assign slp_s3_n     = (fs_q.st != SEQ_PWRCYC);
    assign slp_s4_n     = slp_s3_n;
    assign slp_s5_n     = slp_s3_n;
endmodule

// File: rtl/rstctl_seq_top.sv
module rstctl_seq_top #(
    parameter int unsigned       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] IO_ADDR    = 16'h0CF9,
    parameter int unsigned       INIT_CLKS  = 16,
    parameter int unsigned       TICK_DIV   = 50000,
    parameter int unsigned       HARD_TICKS = 6,
    parameter int unsigned       FULL_TICKS = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsm_rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              ext_rst_req,
    input  logic              pwr_good,
    input  logic              wdt_expire,
    output logic              cpu_init_n,
    output logic              plt_rst_n,
    output logic              sus_stat_n,
    output logic              slp_s3_n,
    output logic              slp_s4_n,
    output logic              slp_s5_n
);
    logic tick, idle, hard_start, cf9_trig, cf9_hard, full_eff, ext_hard;

    rstctl_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rstctl_regfile #(.ADDR_W(ADDR_W), .IO_ADDR(IO_ADDR)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsm_rst_n  (rsm_rst_n),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .hard_clr_i (hard_start),
        .io_rdata   (io_rdata),
        .cf9_trig_o (cf9_trig),
        .cf9_hard_o (cf9_hard),
        .full_eff_o (full_eff)
    );

    rstctl_trig trig_i (
        .clk         (clk),
        .rsm_rst_n   (rsm_rst_n),
        .idle_i      (idle),
        .ext_rst_req (ext_rst_req),
        .pwr_good    (pwr_good),
        .wdt_expire  (wdt_expire),
        .ext_hard_o  (ext_hard)
    );

    rstctl_seq_fsm #(
        .INIT_CLKS  (INIT_CLKS),
        .HARD_TICKS (HARD_TICKS),
        .FULL_TICKS (FULL_TICKS)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .cf9_trig_i   (cf9_trig),
        .cf9_hard_i   (cf9_hard),
        .ext_hard_i   (ext_hard),
        .full_i       (full_eff),
        .idle_o       (idle),
        .hard_start_o (hard_start),
        .cpu_init_n   (cpu_init_n),
        .plt_rst_n    (plt_rst_n),
        .sus_stat_n   (sus_stat_n),
        .slp_s3_n     (slp_s3_n),
        .slp_s4_n     (slp_s4_n),
        .slp_s5_n     (slp_s5_n)
    );
endmodule

// File: rtl/rstctl_seq_chk.sv
module rstctl_seq_chk #(
    parameter int unsigned INIT_CLKS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] io_rdata,
    input logic       cpu_init_n,
    input logic       plt_rst_n,
    input logic       sus_stat_n,
    input logic       slp_s3_n,
    input logic       slp_s4_n,
    input logic       slp_s5_n
);
    localparam int unsigned RW = $clog2(INIT_CLKS + 2) + 1;

    logic [RW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (cpu_init_n)              run_d = '0;
        else if (run_q != {RW{1'b1}}) run_d = run_q + RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rdata[7:4] == 4'h0) && (io_rdata[0] == 1'b0));

    // R3
    init_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(INIT_CLKS));

    // R5
    plt_sus_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plt_rst_n == sus_stat_n);

    // R6
    slp_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_s3_n == slp_s4_n) && (slp_s4_n == slp_s5_n));

    // R6
    slp_in_plt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slp_s3_n |-> !plt_rst_n);

    // R6
    plt_outlasts_slp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slp_s3_n) |-> !plt_rst_n);

    // R11
    init_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_init_n |-> (plt_rst_n && slp_s3_n));
endmodule

bind rstctl_seq_top rstctl_seq_chk #(.INIT_CLKS(INIT_CLKS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_rdata   (io_rdata),
    .cpu_init_n (cpu_init_n),
    .plt_rst_n  (plt_rst_n),
    .sus_stat_n (sus_stat_n),
    .slp_s3_n   (slp_s3_n),
    .slp_s4_n   (slp_s4_n),
    .slp_s5_n   (slp_s5_n)
);

// File: tb/rstctl_seq_top_tb_top.sv
module rstctl_seq_top_tb_top;
    localparam int unsigned INIT = 16;
    localparam int unsigned DIV  = 4;
    localparam int unsigned HT   = 5;
    localparam int unsigned FT   = 12;
    localparam logic [15:0] RA   = 16'h0CF9;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, rsm_rst_n, io_wr, io_rd, ext_rst_req, pwr_good, wdt_expire;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata, io_rdata;
    logic        cpu_init_n, plt_rst_n, sus_stat_n, slp_s3_n, slp_s4_n, slp_s5_n;

    rstctl_seq_top #(
        .ADDR_W(16), .IO_ADDR(RA), .INIT_CLKS(INIT),
        .TICK_DIV(DIV), .HARD_TICKS(HT), .FULL_TICKS(FT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ext_rst_req(ext_rst_req), .pwr_good(pwr_good), .wdt_expire(wdt_expire),
        .cpu_init_n(cpu_init_n), .plt_rst_n(plt_rst_n), .sus_stat_n(sus_stat_n),
        .slp_s3_n(slp_s3_n), .slp_s4_n(slp_s4_n), .slp_s5_n(slp_s5_n)
    );

    int n_vec = 0, n_fail = 0;
    int init_run = 0, init_len = 0, init_cnt = 0;
    int plt_run = 0, plt_len = 0, plt_cnt = 0;
    int slp_run = 0, slp_len = 0, slp_cnt = 0;
    int grp_err = 0;
    bit done = 0;

    function automatic bit in_win(int len, int n);
        return (len > (n - 1) * int'(DIV)) && (len <= n * int'(DIV));
    endfunction

    function automatic logic [7:0] reg_model(logic [7:0] d);
        return d & 8'h0E;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsm_rst_n) begin
            if (!cpu_init_n) init_run++;
            else if (init_run != 0) begin init_len = init_run; init_cnt++; init_run = 0; end
            if (!plt_rst_n) plt_run++;
            else if (plt_run != 0) begin plt_len = plt_run; plt_cnt++; plt_run = 0; end
            if (!slp_s3_n) slp_run++;
            else if (slp_run != 0) begin slp_len = slp_run; slp_cnt++; slp_run = 0; end
            if (plt_rst_n != sus_stat_n || slp_s3_n != slp_s4_n || slp_s4_n != slp_s5_n)
                grp_err++;
        end
    end

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 v = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        if (which == 0) ext_rst_req = 1'b1;
        else if (which == 1) pwr_good = 1'b0;
        else wdt_expire = 1'b1;
        @(negedge clk);
        ext_rst_req = 1'b0; pwr_good = 1'b1; wdt_expire = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] a;
        logic [7:0]  dv, rd, model;
        void'($urandom(32'd1234));
        rst_n = 0; rsm_rst_n = 0; io_wr = 0; io_rd = 0; io_addr = '0; io_wdata = '0;
        ext_rst_req = 0; pwr_good = 1; wdt_expire = 0;
        settle(3);
        rst_n = 1; rsm_rst_n = 1;
        settle(2);

        // R1 reset state
        io_read(RA, rd);
        chk(rd == 8'h00, "R1 read after reset", rd, 0);
        chk({cpu_init_n, plt_rst_n, sus_stat_n, slp_s3_n, slp_s4_n, slp_s5_n} == 6'h3F,
            "R1 outputs idle", int'({cpu_init_n, plt_rst_n, sus_stat_n, slp_s3_n, slp_s4_n, slp_s5_n}), 63);

        // R2 random register traffic, bit 2 kept clear
        model = 8'h00;
        for (int i = 0; i < 40; i++) begin
            a  = ($urandom % 2 == 0) ? RA : (RA ^ 16'(($urandom % 65535) + 1));
            dv = 8'($urandom) & 8'hFB;
            io_write(a, dv);
            if (a == RA) model = reg_model(dv);
            io_read(RA, rd);
            chk(rd == model, "R2 random read-back", rd, model);
        end
        io_read(RA - 16'd1, rd);
        chk(rd == 8'h00, "R2 other address reads 0", rd, 0);
        chk(init_cnt == 0 && plt_cnt == 0, "R2 no sequence from plain writes", plt_cnt + init_cnt, 0);
        io_write(RA, 8'h00);

        // R3 soft reset
        io_write(RA, 8'h04);
        chk(cpu_init_n == 1'b0, "R3 init low after write", cpu_init_n, 0);
        settle(30);
        chk(init_cnt == 1 && init_len == int'(INIT), "R3 init length", init_len, INIT);
        chk(plt_cnt == 0 && slp_cnt == 0, "R3 hard outputs quiet", plt_cnt, 0);
        io_read(RA, rd);
        chk(rd == 8'h04, "R3 register after soft", rd, 4);

        // R4 no retrigger
        io_write(RA, 8'h06);
        settle(30);
        chk(init_cnt == 1 && plt_cnt == 0, "R4 no new sequence", plt_cnt, 0);
        io_read(RA, rd);
        chk(rd == 8'h06, "R4 register stored", rd, 6);

        // R5 hard reset without full cycle
        io_write(RA, 8'h02);
        io_write(RA, 8'h06);
        chk(plt_rst_n == 1'b0, "R5 platform reset low after write", plt_rst_n, 0);
        settle(60);
        chk(plt_cnt == 1 && in_win(plt_len, HT), "R5 platform reset window", plt_len, HT * DIV);
        chk(slp_cnt == 0, "R5 sleep outputs stay high", slp_cnt, 0);
        io_read(RA, rd);
        chk(rd == 8'h00, "R7 hard clears bits 2:1", rd, 0);

        // R6 full power cycle, full bit set by the same write
        io_write(RA, 8'h0E);
        settle(100);
        chk(slp_cnt == 1 && in_win(slp_len, FT), "R6 sleep window", slp_len, FT * DIV);
        chk(plt_cnt == 2 && plt_len == slp_len + int'(HT * DIV), "R6 platform tail", plt_len, slp_len + HT * DIV);
        io_read(RA, rd);
        chk(rd == 8'h08, "R7 full bit kept through hard", rd, 8);

        // R11 triggers while busy are dropped
        io_write(RA, 8'h0E);
        settle(8);
        pulse(0);
        io_write(RA, 8'h0C);
        settle(100);
        chk(init_cnt == 1, "R11 soft write while busy ignored", init_cnt, 1);
        chk(plt_cnt == 3 && slp_cnt == 2, "R11 single sequence", plt_cnt, 3);
        chk(in_win(slp_len, FT) && plt_len == slp_len + int'(HT * DIV), "R11 lengths unchanged", plt_len, slp_len + HT * DIV);
        io_read(RA, rd);
        chk(rd == 8'h0C, "R11 write while busy lands", rd, 12);

        // R8 external request, both forms
        io_write(RA, 8'h08);
        pulse(0);
        settle(100);
        chk(slp_cnt == 3 && plt_cnt == 4 && in_win(slp_len, FT), "R8 full cycle from request", slp_cnt, 3);
        io_write(RA, 8'h00);
        pulse(0);
        settle(60);
        chk(plt_cnt == 5 && slp_cnt == 3 && in_win(plt_len, HT), "R8 plain hard from request", plt_cnt, 5);

        // R9 power-good fall
        pulse(1);
        settle(60);
        chk(plt_cnt == 6 && in_win(plt_len, HT), "R9 power-good fall", plt_cnt, 6);

        // R10 watchdog twice
        pulse(2);
        settle(30);
        chk(plt_cnt == 6, "R10 first expiry only arms", plt_cnt, 6);
        pulse(2);
        settle(60);
        chk(plt_cnt == 7, "R10 second expiry resets", plt_cnt, 7);
        pulse(2);
        settle(30);
        chk(plt_cnt == 7, "R10 disarmed after firing", plt_cnt, 7);

        // R12 soft write and external request in one cycle
        @(negedge clk);
        io_addr = RA; io_wdata = 8'h04; io_wr = 1'b1; ext_rst_req = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; ext_rst_req = 1'b0;
        chk(cpu_init_n == 1'b1 && plt_rst_n == 1'b0, "R12 hard wins", int'(cpu_init_n), 1);
        settle(60);
        chk(init_cnt == 1 && plt_cnt == 8, "R12 one hard pulse only", plt_cnt, 8);
        io_read(RA, rd);
        chk(rd == 8'h00, "R12 bits 2:1 cleared", rd, 0);

        // R7 reset wells
        io_write(RA, 8'h0A);
        io_read(RA, rd);
        chk(rd == 8'h0A, "R7 write before resets", rd, 10);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        io_read(RA, rd);
        chk(rd == 8'h08, "R7 main reset keeps full bit", rd, 8);
        @(negedge clk); rsm_rst_n = 0;
        @(negedge clk); rsm_rst_n = 1;
        io_read(RA, rd);
        chk(rd == 8'h00, "R7 resume reset clears full bit", rd, 0);
        chk(plt_rst_n && slp_s3_n && cpu_init_n, "R1 outputs idle after resets", int'(plt_rst_n), 1);

        chk(grp_err == 0, "R6 grouped outputs agree", grp_err, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule